// File: doc/BRIEF.md
# Parallel RGB display output formatter

This block drives a parallel RGB panel bus from a stream of 24-bit pixels. On every rising clock edge it takes one pixel together with its horizontal sync, vertical sync and data-enable flags. It then drives a registered 24-bit output bus, the three control lines and a forwarded pixel clock. The pixel first passes through a channel-order shuffle. Its channels are then cut down to 8-8-8, 6-6-6 or 5-6-5 and placed onto the bus in one of several fixed layouts, some of which leave zero gaps between the colour fields. Each control line has its own polarity, falling-edge and force-off settings. The forwarded clock can be inverted.

All settings sit in one 17-bit control word written over a simple register bus. Reads at any other offset return a fixed identification constant. Bit 0 of the control word gates the whole output. While it is low, the bus is zero and every control line sits at its inactive level. Setting bit 0 after it was clear costs one flush cycle before pixels flow again.

Top module: `rgb_out_fmt`

## Requirements
- R1: After synchronous reset, the control word is 0, `out_data` is 0, `out_hs`/`out_vs`/`out_de` are 0, `reg_rdata` is 0, and `out_pclk` is 0 during the high phase of `clk`.
- R2: A write with `reg_addr` = 0 loads control bits [16:0]. `reg_rdata` is registered. One cycle after an address is presented, it returns {15'b0, control word} for address 0 and 32'h00647069 for any other address.
- R3: Control bits [15:14] reorder the channels (R = bits 23:16, G = 15:8, B = 7:0 of `pix_rgb`) into slots (first, second, third): 0 gives R,G,B; 1 gives B,G,R; 2 gives G,R,B; 3 gives B,R,G.
- R4: Control bits [13:11] select the packing of the slots s1,s2,s3, with reductions keeping the top bits. 1: {8'b0,s1[7:3],s2[7:2],s3[7:3]}. 2: {3'b0,s1[7:3],2'b0,s2[7:2],3'b0,s3[7:3]}. 3: {2'b0,s1[7:3],3'b0,s2[7:2],2'b0,s3[7:3],1'b0}. 4: {6'b0,s1[7:2],s2[7:2],s3[7:2]}. 5: {2'b0,s1[7:2],2'b0,s2[7:2],2'b0,s3[7:2]}. 6: {s1,s2,s3}. Codes 0 and 7 drive zero.
- R5: A pixel sampled at rising edge k appears on `out_data` after edge k, which is one cycle of latency.
- R6: While control bit 0 is low, `out_data` is 0 and each control line equals its invert bit (its inactive level 0 after inversion).
- R7: A 0-to-1 change of control bit 0 flushes the datapath. At the first edge after the enabling write, the outputs stay in the idle state of R6. The pixel at the second edge is the first one shown.
- R8: Control bits 9, 8 and 7 invert hsync, vsync and enable. Bit 10 inverts the forwarded clock, so `out_pclk` = (`clk` AND bit 0) XOR bit 10.
- R9: Control bits 6, 5 and 4 make hsync, vsync and enable change on the falling edge. The line then shows the value it would have had half a cycle later, so during the high phase after edge k it still shows the edge k-1 value.
- R10: Control bits 3, 2 and 1 force hsync, vsync and enable inactive. The line then equals its invert bit, one cycle after the setting takes effect.
- R11: Control bit 16 set makes the enable line follow `pix_de`. Cleared, the enable line is active on every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pix_rgb | input | 3*CH_W | Input pixel, R in the top channel |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| pix_de | input | 1 | Input data enable |
| out_data | output | 3*CH_W | Packed panel data |
| out_hs | output | 1 | Panel horizontal sync |
| out_vs | output | 1 | Panel vertical sync |
| out_de | output | 1 | Panel output enable |
| out_pclk | output | 1 | Forwarded pixel clock |

## Verification
The bench builds the block with CH_W = 8 and ADDR_W = 4. At that channel width every packing layout fills the bus exactly, so each gap bit and truncated low bit is visible on the 24 output lines. Four address bits give offset 0 and three identification offsets to read. A behavioural model compares every output on every cycle while all orders, all eight format codes, all invert, falling-edge and force-off combinations, both enable modes and repeated enable restarts are stepped through.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

  localparam int          CTRL_W = 17;
  localparam logic [31:0] IDENT  = 32'h0064_7069;

  // line index inside the three-line control group
  localparam int LN_DE = 0;
  localparam int LN_VS = 1;
  localparam int LN_HS = 2;
  localparam int N_LN  = 3;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    PK_BLANK     = 3'd0,
    PK_565_LOW   = 3'd1,
    PK_565_GAPA  = 3'd2,
    PK_565_GAPB  = 3'd3,
    PK_666_LOW   = 3'd4,
    PK_666_GAP   = 3'd5,
    PK_888       = 3'd6,
    PK_SPARE     = 3'd7
  } pack_e;

  // bit order of the control word is decoded by software; keep it fixed
  typedef struct packed {
    logic           de_follow;   // 16
    order_e         order;       // 15:14
    pack_e          pack;        // 13:11
    logic           clk_inv;     // 10
    logic [N_LN-1:0] inv;        // 9:7  (hs, vs, de)
    logic [N_LN-1:0] late;       // 6:4
    logic [N_LN-1:0] off;        // 3:1
    logic           run;         // 0
  } ctrl_t;

endpackage

// File: rtl/rgbfmt_regs.sv
module rgbfmt_regs
  import rgbfmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [31:0]       rdata,
  output ctrl_t             ctrl,
  output logic              restart
);

  ctrl_t ctrl_q;
  logic  run_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      run_d  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr && addr == '0)
        ctrl_q <= ctrl_t'(wdata);
      run_d <= ctrl_q.run;
      if (addr == '0)
        rdata <= {{(32-CTRL_W){1'b0}}, ctrl_q};
      else
        rdata <= IDENT;
    end
  end

  assign ctrl    = ctrl_q;
  assign restart = ctrl_q.run & ~run_d;

  // R2: a write to offset 0 is visible in the control word on the next cycle
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == '0) |=> (ctrl_q == ctrl_t'($past(wdata))));

  // R2: any nonzero offset reads the identification constant
  a_r2_ident_read: assert property (@(posedge clk) disable iff (rst)
    (addr != '0) |=> (rdata == IDENT));

  // R7: the restart flush lasts exactly one cycle
  a_r7_restart_single: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart);

endmodule

// File: rtl/rgbfmt_pixpath.sv
module rgbfmt_pixpath
  import rgbfmt_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  order_e            order,
  input  pack_e             pack,
  input  logic [3*CH_W-1:0] pix,
  output logic [3*CH_W-1:0] data
);

  localparam int BUS_W = 3 * CH_W;
  localparam int PK_W  = 24;

  logic [CH_W-1:0] red, grn, blu;
  logic [CH_W-1:0] s1, s2, s3;
  logic [4:0]      s1_5, s3_5;
  logic [5:0]      s1_6, s2_6, s3_6;
  logic [PK_W-1:0] packed_v;
  logic [BUS_W-1:0] data_q;

  assign red = pix[3*CH_W-1 -: CH_W];
  assign grn = pix[2*CH_W-1 -: CH_W];
  assign blu = pix[CH_W-1   -: CH_W];

  // channel shuffle
  always_comb begin
    unique case (order)
      ORD_BGR: begin s1 = blu; s2 = grn; s3 = red; end
      ORD_GRB: begin s1 = grn; s2 = red; s3 = blu; end
      ORD_BRG: begin s1 = blu; s2 = red; s3 = grn; end
      default: begin s1 = red; s2 = grn; s3 = blu; end
    endcase
  end

  // colour reduction keeps the top bits of each channel
  assign s1_5 = s1[CH_W-1 -: 5];
  assign s3_5 = s3[CH_W-1 -: 5];
  assign s1_6 = s1[CH_W-1 -: 6];
  assign s2_6 = s2[CH_W-1 -: 6];
  assign s3_6 = s3[CH_W-1 -: 6];

  // bus layouts
  always_comb begin
    unique case (pack)
      PK_565_LOW:  packed_v = {8'b0, s1_5, s2_6, s3_5};
      PK_565_GAPA: packed_v = {3'b0, s1_5, 2'b0, s2_6, 3'b0, s3_5};
      PK_565_GAPB: packed_v = {2'b0, s1_5, 3'b0, s2_6, 2'b0, s3_5, 1'b0};
      PK_666_LOW:  packed_v = {6'b0, s1_6, s2_6, s3_6};
      PK_666_GAP:  packed_v = {2'b0, s1_6, 2'b0, s2_6, 2'b0, s3_6};
      PK_888:      packed_v = {s1[CH_W-1 -: 8], s2[CH_W-1 -: 8], s3[CH_W-1 -: 8]};
      default:     packed_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      data_q <= '0;
    else
      data_q <= BUS_W'(packed_v);
  end

  assign data = data_q;

  // R6: an idle or flush cycle leaves the bus at zero
  a_r6_bus_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (data_q == '0));

endmodule

// File: rtl/rgbfmt_sigline.sv
module rgbfmt_sigline (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic src,
  input  logic inv,
  input  logic late,
  input  logic off,
  output logic line
);

  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk) begin
    if (rst)
      rise_q <= 1'b0;
    else if (clr)
      rise_q <= inv;
    else
      rise_q <= (src & ~off) ^ inv;
  end

  // half-cycle retimed copy for falling-edge launch
  always_ff @(negedge clk) begin
    fall_q <= rise_q;
  end

  assign line = late ? fall_q : rise_q;

  // R6: idle or flush drives the inactive level
  a_r6_line_idle: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rise_q == $past(inv)));

  // R10: a forced-off line sits at its inactive level
  a_r10_line_off: assert property (@(posedge clk) disable iff (rst)
    (!clr && off) |=> (rise_q == $past(inv)));

endmodule

// File: rtl/rgb_out_fmt.sv
module rgb_out_fmt
  import rgbfmt_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3*CH_W-1:0] pix_rgb,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic              pix_de,
  output logic [3*CH_W-1:0] out_data,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_de,
  output logic              out_pclk
);

  ctrl_t           ctrl;
  logic            restart;
  logic            clr;
  logic [N_LN-1:0] src;
  logic [N_LN-1:0] lines;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata[31:CTRL_W];

  rgbfmt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata[CTRL_W-1:0]),
    .rdata   (reg_rdata),
    .ctrl    (ctrl),
    .restart (restart)
  );

  assign clr = ~ctrl.run | restart;

  rgbfmt_pixpath #(.CH_W(CH_W)) u_pix (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .order (ctrl.order),
    .pack  (ctrl.pack),
    .pix   (pix_rgb),
    .data  (out_data)
  );

  assign src[LN_HS] = pix_hs;
  assign src[LN_VS] = pix_vs;
  assign src[LN_DE] = ctrl.de_follow ? pix_de : 1'b1;

  for (genvar i = 0; i < N_LN; i++) begin : g_line
    rgbfmt_sigline u_line (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .src  (src[i]),
      .inv  (ctrl.inv[i]),
      .late (ctrl.late[i]),
      .off  (ctrl.off[i]),
      .line (lines[i])
    );
  end

  assign out_hs = lines[LN_HS];
  assign out_vs = lines[LN_VS];
  assign out_de = lines[LN_DE];

  // forwarded clock, gated by the run bit, optional inversion
  assign out_pclk = (clk & ctrl.run) ^ ctrl.clk_inv;

  // R8: with run low the forwarded clock is a constant at its invert level
  a_r8_pclk_parked: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run) |-> (out_pclk == ctrl.clk_inv));

endmodule

// File: tb/test_rgb_out_fmt.sv
module test_rgb_out_fmt;

  localparam int CH_W   = 8;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 3 * CH_W;
  localparam logic [31:0] ID_VAL = 32'h0064_7069;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [BUS_W-1:0]  pix_rgb;
  logic              pix_hs, pix_vs, pix_de;
  logic [BUS_W-1:0]  out_data;
  logic              out_hs, out_vs, out_de, out_pclk;

  always #2 clk = ~clk;

  rgb_out_fmt #(.CH_W(CH_W), .ADDR_W(ADDR_W)) i_rgb_out_fmt (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .pix_rgb, .pix_hs, .pix_vs, .pix_de,
    .out_data, .out_hs, .out_vs, .out_de, .out_pclk
  );

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // model state
  logic [16:0] m_ctrl = '0;
  logic        m_end = 0;
  logic [23:0] m_data = '0;
  logic [2:0]  m_rise = '0;
  logic [2:0]  m_fall = '0;
  logic [31:0] m_rdata = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [23:0] ref_pack(input logic [16:0] c, input logic [23:0] p);
    int r, g, b, t1, t2, t3, v;
    r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]);
    case (c[15:14])
      2'd1: begin t1 = b; t2 = g; t3 = r; end
      2'd2: begin t1 = g; t2 = r; t3 = b; end
      2'd3: begin t1 = b; t2 = r; t3 = g; end
      default: begin t1 = r; t2 = g; t3 = b; end
    endcase
    case (c[13:11])
      3'd1: v = ((t1 >> 3) << 11) | ((t2 >> 2) << 5) | (t3 >> 3);
      3'd2: v = ((t1 >> 3) << 16) | ((t2 >> 2) << 8) | (t3 >> 3);
      3'd3: v = ((t1 >> 3) << 17) | ((t2 >> 2) << 8) | ((t3 >> 3) << 1);
      3'd4: v = ((t1 >> 2) << 12) | ((t2 >> 2) << 6) | (t3 >> 2);
      3'd5: v = ((t1 >> 2) << 16) | ((t2 >> 2) << 8) | (t3 >> 2);
      3'd6: v = (t1 << 16) | (t2 << 8) | t3;
      default: v = 0;
    endcase
    return v[23:0];
  endfunction

  // reference model, stepped at each rising edge, compared in the high phase
  always @(posedge clk) begin
    logic [16:0] c;
    logic [2:0]  srcs;
    logic        clr;
    cyc++;
    c = m_ctrl;
    m_fall = m_rise;
    if (rst) begin
      m_ctrl = '0; m_end = 0; m_data = '0; m_rise = '0; m_rdata = '0;
    end else begin
      clr = !c[0] || !m_end;
      srcs = {pix_hs, pix_vs, c[16] ? pix_de : 1'b1};
      for (int i = 0; i < 3; i++)
        m_rise[i] = clr ? c[7+i] : ((srcs[i] & !c[1+i]) ^ c[7+i]);
      m_data = clr ? 24'h0 : ref_pack(c, pix_rgb);
      m_rdata = (reg_addr == 0) ? {15'b0, c} : ID_VAL;
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata[16:0];
      m_end = c[0];
    end
    #1;
    if (cyc > 2 && !finished) begin
      chk("out_data", 32'(out_data), 32'(m_data));
      chk("out_hs", 32'(out_hs), 32'(m_ctrl[6] ? m_fall[2] : m_rise[2]));
      chk("out_vs", 32'(out_vs), 32'(m_ctrl[5] ? m_fall[1] : m_rise[1]));
      chk("out_de", 32'(out_de), 32'(m_ctrl[4] ? m_fall[0] : m_rise[0]));
      chk("out_pclk", 32'(out_pclk), 32'(m_ctrl[0] ^ m_ctrl[10]));
      chk("reg_rdata", reg_rdata, m_rdata);
    end
  end

  function automatic logic [31:0] mk(input bit dfol, input logic [1:0] ord, input logic [2:0] pk,
                                     input bit pinv, input logic [2:0] inv, input logic [2:0] late,
                                     input logic [2:0] off, input bit run);
    return {15'b0, dfol, ord, pk, pinv, inv, late, off, run};
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    reg_wr = 1; reg_addr = '0; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0; reg_wdata = $urandom;
  endtask

  task automatic stream(input int n);
    repeat (n) begin
      pix_rgb  = 24'($urandom);
      pix_hs   = 1'($urandom);
      pix_vs   = 1'($urandom);
      pix_de   = 1'($urandom);
      reg_addr = ADDR_W'(($urandom % 4) * 4);
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    pix_rgb = '0; pix_hs = 0; pix_vs = 0; pix_de = 0;
    repeat (5) @(negedge clk);
    cur_req = "R1";
    // R1: reset state, ports at zero before any write
    chk("R1 out_data", 32'(out_data), 0);
    chk("R1 lines", {29'b0, out_hs, out_vs, out_de}, 0);
    chk("R1 rdata", reg_rdata, 0);
    rst = 0;
    stream(3);

    cur_req = "R2";
    stream(12);
    wr_ctrl(mk(1, 2'd2, 3'd5, 1, 3'b101, 3'b010, 3'b001, 0));
    stream(12);

    cur_req = "R6";
    wr_ctrl(mk(1, 2'd0, 3'd6, 1, 3'b111, 3'b000, 3'b000, 0));
    stream(20);

    cur_req = "R7";
    wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'b000, 3'b000, 3'b000, 1));
    stream(10);
    wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'b010, 3'b000, 3'b000, 0));
    stream(3);
    wr_ctrl(mk(1, 2'd1, 3'd6, 0, 3'b010, 3'b000, 3'b000, 1));
    stream(8);

    cur_req = "R5";
    wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'b000, 3'b000, 3'b000, 1));
    stream(20);

    cur_req = "R3";
    for (int o = 0; o < 4; o++) begin
      wr_ctrl(mk(1, 2'(o), 3'd6, 0, 3'b000, 3'b000, 3'b000, 1));
      stream(15);
    end

    cur_req = "R4";
    for (int f = 0; f < 8; f++) begin
      wr_ctrl(mk(1, 2'd3, 3'(f), 0, 3'b000, 3'b000, 3'b000, 1));
      stream(15);
      wr_ctrl(mk(1, 2'd0, 3'(f), 0, 3'b000, 3'b000, 3'b000, 1));
      stream(15);
    end

    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      wr_ctrl(mk(1, 2'd0, 3'd6, k[0], 3'(k), 3'b000, 3'b000, 1));
      stream(10);
    end

    cur_req = "R9";
    for (int k = 0; k < 8; k++) begin
      wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'(k) ^ 3'b101, 3'(k), 3'b000, 1));
      stream(12);
    end

    cur_req = "R10";
    for (int k = 0; k < 8; k++) begin
      wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'(7 - k), 3'b000, 3'(k), 1));
      stream(10);
    end

    cur_req = "R11";
    wr_ctrl(mk(0, 2'd0, 3'd6, 0, 3'b000, 3'b000, 3'b000, 1));
    stream(20);
    wr_ctrl(mk(0, 2'd0, 3'd6, 0, 3'b001, 3'b001, 3'b000, 1));
    stream(10);
    wr_ctrl(mk(1, 2'd0, 3'd6, 0, 3'b000, 3'b000, 3'b000, 1));
    stream(20);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule